// File: doc/BRIEF.md
# Pipelined Multiply-Add Slice

This block is an arithmetic slice built around a signed 25 x 18 multiplier and a 48-bit three-operand adder/subtracter. Three operand selectors, called X, Y and Z, choose what reaches the adder: the product, the registered result (for accumulation), a wide constant input, a cascade input, the two data inputs joined into one 48-bit word, an all-ones word, or a copy of the cascade input or the result shifted right by 17 bits. A 7-bit operation word drives the selectors and may change on every clock. A 4-bit arithmetic word chooses between adding and subtracting.

Every control word travels down the pipeline beside the operands it was issued with. A new operation can start on every cycle, and an accumulate-style sequence reads back the result of the operation issued one cycle before it. The registered result also drives a cascade output and two comparison flags against a fixed pattern. Carry-outs are reported for each 12-bit section of the adder. Selector pairings that cannot be built raise an error flag, and the result register holds its value when that happens.

Top module: `mac_slice`

## Requirements
- R1: When the operation word's X field (bits 1:0) and Y field (bits 3:2) are both 01, the slice adds the signed product of a_i[24:0] and b_i (sign-extended to 48 bits) into the sum. Bits a_i[29:25] have no effect on the product.
- R2: X field sources: 00 selects zero, 10 selects the current result p_o, and 11 selects {a_i, b_i} as one 48-bit word.
- R3: Y field sources: 00 selects zero, 10 selects all ones, and 11 selects c_i.
- R4: Z field (bits 6:4) sources: 000 selects zero, 001 selects casc_i, 011 selects c_i, and both 010 and 100 select the current result p_o.
- R5: Z field 101 selects casc_i shifted right by 17 with sign extension. Z field 110 selects p_o shifted right by 17 with sign extension.
- R6: With arithmetic word 0000 the result is Z + X + Y + carry-in. With 0011 it is Z - (X + Y + carry-in). Both are taken modulo 2^48.
- R7: The operation is illegal, and mode_err_o is 1 for it, in three cases: exactly one of the X and Y fields is 01, the Z field is 111, or the arithmetic word is neither 0000 nor 0011. For an illegal operation p_o and carry_o keep their previous values. The next legal operation clears mode_err_o.
- R8: Let W = (X + Y + carry-in) mod 2^48. An add forms Z + W; a subtract forms Z + ~W + 1. carry_o[k] is the carry out of bit 12k+11 of that sum. carry_o[3] is forced to 0 whenever the product is selected.
- R9: pat_hit_o is 1 exactly when p_o equals PATTERN. pat_inv_hit_o is 1 exactly when p_o equals ~PATTERN.
- R10: The result of an operation appears on p_o, carry_o and mode_err_o AB_STAGES+2 rising edges after the edge that sampled its inputs. Operations issued on consecutive cycles each use their own operation word. An operation that selects p_o sees the result of the operation issued one cycle earlier.
- R11: While rst_n is low, p_o, carry_o, casc_o and mode_err_o are 0.
- R12: While ce_p is low, p_o, carry_o and mode_err_o hold their values. While ce_ab is low, the input stage keeps the operation it holds. While ce_m is low, the product stage keeps its contents.
- R13: casc_o always equals p_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_ab | input | 1 | Enable for the input register stages |
| ce_m | input | 1 | Enable for the product stage |
| ce_p | input | 1 | Enable for the result stage |
| a_i | input | 30 | Operand A; the low 25 bits feed the multiplier |
| b_i | input | 18 | Operand B |
| c_i | input | 48 | Wide operand C |
| casc_i | input | 48 | Cascade input from a neighbouring slice |
| cin_i | input | 1 | Carry-in |
| opmode_i | input | 7 | Operation word: Z[6:4], Y[3:2], X[1:0] |
| alumode_i | input | 4 | Arithmetic word: 0000 add, 0011 subtract |
| p_o | output | 48 | Registered result |
| carry_o | output | 4 | Registered carry-out per 12-bit section |
| casc_o | output | 48 | Cascade output, a copy of the result |
| pat_hit_o | output | 1 | Result equals PATTERN |
| pat_inv_hit_o | output | 1 | Result equals the inverse of PATTERN |
| mode_err_o | output | 1 | Last captured operation was illegal |

## Verification
With the default single input stage, each operation's result, carry bits and error flag are due three rising edges after the edge that samples its inputs. The pattern flags and the cascade output change in the same cycle as the result, because they are decoded from the result register. The driver records, for every item it issues, the cycle number in which that item is due. The monitor compares outputs at the falling edge of exactly that cycle. Operations are issued back to back on every cycle, so the model can carry the previous result forward in issue order. The clock-enable cases are driven as directed sequences: they keep the inputs steady for several cycles and then count the edges after each enable returns.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  localparam int A_W    = 30;
  localparam int B_W    = 18;
  localparam int D_W    = 48;
  localparam int AM_W   = 25;
  localparam int PROD_W = AM_W + B_W;
  localparam int OPM_W  = 7;
  localparam int ALU_W  = 4;
  localparam int SEG_W  = 12;
  localparam int NSEG   = D_W / SEG_W;
  localparam int SHR    = 17;

  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0011;

  // operands and controls that travel together down the pipeline
  typedef struct packed {
    logic [A_W-1:0]   a;
    logic [B_W-1:0]   b;
    logic [D_W-1:0]   c;
    logic [D_W-1:0]   casc;
    logic             cin;
    logic [OPM_W-1:0] opmode;
    logic [ALU_W-1:0] alumode;
  } ops_t;

endpackage

// File: rtl/slice_delay.sv
module slice_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (ce) begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/mult_stage.sv
module mult_stage
  import mac_slice_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  ops_t           ops_i,
  output logic [D_W-1:0] prod_o,
  output ops_t           ops_o
);

  logic signed [PROD_W-1:0] prod_raw;
  logic [D_W-1:0]           prod_d;

  always_comb begin
    prod_raw = $signed(ops_i.a[AM_W-1:0]) * $signed(ops_i.b);
    prod_d   = {{(D_W-PROD_W){prod_raw[PROD_W-1]}}, prod_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      ops_o  <= '0;
    end else if (ce) begin
      prod_o <= prod_d;
      ops_o  <= ops_i;
    end
  end

endmodule

// File: rtl/post_adder.sv
module post_adder
  import mac_slice_pkg::*;
(
  input  logic [D_W-1:0]   prod_i,
  input  logic [D_W-1:0]   ab_i,
  input  logic [D_W-1:0]   c_i,
  input  logic [D_W-1:0]   casc_i,
  input  logic [D_W-1:0]   p_i,
  input  logic             cin_i,
  input  logic [OPM_W-1:0] opmode_i,
  input  logic [ALU_W-1:0] alumode_i,
  output logic [D_W-1:0]   res_o,
  output logic [NSEG-1:0]  carry_o,
  output logic             illegal_o,
  output logic             mult_sel_o
);

  logic [1:0]     xsel, ysel;
  logic [2:0]     zsel;
  logic [D_W-1:0] xv, yv, zv, wsum, op2;
  logic           sub;
  logic [NSEG:0]  chain;

  assign xsel = opmode_i[1:0];
  assign ysel = opmode_i[3:2];
  assign zsel = opmode_i[6:4];

  always_comb begin
    mult_sel_o = (xsel == 2'b01) && (ysel == 2'b01);
    illegal_o  = ((xsel == 2'b01) != (ysel == 2'b01)) || (zsel == 3'b111) ||
                 !((alumode_i == ALU_ADD) || (alumode_i == ALU_SUB));

    unique case (xsel)
      2'b00:   xv = '0;
      2'b01:   xv = prod_i;
      2'b10:   xv = p_i;
      default: xv = ab_i;
    endcase

    unique case (ysel)
      2'b10:   yv = '1;
      2'b11:   yv = c_i;
      default: yv = '0;
    endcase

    unique case (zsel)
      3'b001:  zv = casc_i;
      3'b010:  zv = p_i;
      3'b011:  zv = c_i;
      3'b100:  zv = p_i;
      3'b101:  zv = $signed(casc_i) >>> SHR;
      3'b110:  zv = $signed(p_i) >>> SHR;
      default: zv = '0;
    endcase

    sub  = (alumode_i == ALU_SUB);
    wsum = xv + yv + {{(D_W-1){1'b0}}, cin_i};
    op2  = sub ? ~wsum : wsum;
  end

  assign chain[0] = sub;

  generate
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      assign {chain[k+1], res_o[k*SEG_W +: SEG_W]} =
          {1'b0, zv[k*SEG_W +: SEG_W]} + {1'b0, op2[k*SEG_W +: SEG_W]} +
          {{SEG_W{1'b0}}, chain[k]};
    end
  endgenerate

  assign carry_o = {chain[NSEG] & ~mult_sel_o, chain[NSEG-1:1]};

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int             AB_STAGES = 1,
  parameter logic [D_W-1:0] PATTERN   = 48'h0000_0000_0ABC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_ab,
  input  logic             ce_m,
  input  logic             ce_p,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [D_W-1:0]   c_i,
  input  logic [D_W-1:0]   casc_i,
  input  logic             cin_i,
  input  logic [OPM_W-1:0] opmode_i,
  input  logic [ALU_W-1:0] alumode_i,
  output logic [D_W-1:0]   p_o,
  output logic [NSEG-1:0]  carry_o,
  output logic [D_W-1:0]   casc_o,
  output logic             pat_hit_o,
  output logic             pat_inv_hit_o,
  output logic             mode_err_o
);

  ops_t            in_ops, a_ops, m_ops;
  logic [D_W-1:0]  m_prod, res_w;
  logic [NSEG-1:0] cy_w;
  logic            illegal_w, mult_sel_w;

  logic [D_W-1:0]  p_q, p_d;
  logic [NSEG-1:0] cy_q, cy_d;
  logic            err_q, err_d;

  assign in_ops = {a_i, b_i, c_i, casc_i, cin_i, opmode_i, alumode_i};

  slice_delay #(.W($bits(ops_t)), .DEPTH(AB_STAGES)) u_in_pipe (
    .clk (clk), .rst_n (rst_n), .ce (ce_ab), .d (in_ops), .q (a_ops)
  );

  mult_stage u_mul (
    .clk (clk), .rst_n (rst_n), .ce (ce_m),
    .ops_i (a_ops), .prod_o (m_prod), .ops_o (m_ops)
  );

  post_adder u_add (
    .prod_i     (m_prod),
    .ab_i       ({m_ops.a, m_ops.b}),
    .c_i        (m_ops.c),
    .casc_i     (m_ops.casc),
    .p_i        (p_q),
    .cin_i      (m_ops.cin),
    .opmode_i   (m_ops.opmode),
    .alumode_i  (m_ops.alumode),
    .res_o      (res_w),
    .carry_o    (cy_w),
    .illegal_o  (illegal_w),
    .mult_sel_o (mult_sel_w)
  );

  // result stage: next state
  always_comb begin
    p_d   = p_q;
    cy_d  = cy_q;
    err_d = err_q;
    if (ce_p) begin
      err_d = illegal_w;
      if (!illegal_w) begin
        p_d  = res_w;
        cy_d = cy_w;
      end
    end
  end

  // result stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= '0;
      cy_q  <= '0;
      err_q <= 1'b0;
    end else begin
      p_q   <= p_d;
      cy_q  <= cy_d;
      err_q <= err_d;
    end
  end

  assign p_o           = p_q;
  assign casc_o        = p_q;
  assign carry_o       = cy_q;
  assign mode_err_o    = err_q;
  assign pat_hit_o     = (p_q == PATTERN);
  assign pat_inv_hit_o = (p_q == ~PATTERN);

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_p,
  input logic        illegal,
  input logic        mult_sel,
  input logic [47:0] p_o,
  input logic [3:0]  carry_o,
  input logic        mode_err_o
);

  // R12
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_p |=> ($stable(p_o) && $stable(carry_o) && $stable(mode_err_o)));

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && illegal) |=> (mode_err_o && $stable(p_o) && $stable(carry_o)));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && !illegal) |=> !mode_err_o);

  // R8
  mult_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && mult_sel && !illegal) |=> !carry_o[3]);

endmodule

bind mac_slice mac_slice_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_p       (ce_p),
  .illegal    (illegal_w),
  .mult_sel   (mult_sel_w),
  .p_o        (p_o),
  .carry_o    (carry_o),
  .mode_err_o (mode_err_o)
);

// File: tb/mac_slice_tb.sv
module mac_slice_tb;

  localparam int          D   = 1;
  localparam int          LAT = D + 2;
  localparam logic [47:0] PAT = 48'h0000_0000_0ABC;
  localparam logic [3:0]  ADD = 4'b0000;
  localparam logic [3:0]  SUB = 4'b0011;
  localparam logic [6:0]  IDLE = 7'b010_00_00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_ab = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
  logic [29:0] a_i = '0;
  logic [17:0] b_i = '0;
  logic [47:0] c_i = '0, casc_i = '0;
  logic        cin_i = 1'b0;
  logic [6:0]  opmode_i = '0;
  logic [3:0]  alumode_i = '0;
  logic [47:0] p_o, casc_o;
  logic [3:0]  carry_o;
  logic        pat_hit_o, pat_inv_hit_o, mode_err_o;

  mac_slice #(.AB_STAGES(D), .PATTERN(PAT)) u_dut (
    .clk (clk), .rst_n (rst_n), .ce_ab (ce_ab), .ce_m (ce_m), .ce_p (ce_p),
    .a_i (a_i), .b_i (b_i), .c_i (c_i), .casc_i (casc_i), .cin_i (cin_i),
    .opmode_i (opmode_i), .alumode_i (alumode_i),
    .p_o (p_o), .carry_o (carry_o), .casc_o (casc_o),
    .pat_hit_o (pat_hit_o), .pat_inv_hit_o (pat_inv_hit_o), .mode_err_o (mode_err_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct packed {
    logic [31:0] due;
    logic [47:0] p;
    logic [3:0]  cy;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [47:0] mp = '0;
  logic [3:0]  mc = '0;

  function automatic logic [6:0] opm(input logic [2:0] z, input logic [1:0] y, input logic [1:0] x);
    return {z, y, x};
  endfunction

  // expected outcome computed from the requirement text
  function automatic void model(
    input  logic [6:0] op, input logic [3:0] alu, input logic [29:0] a, input logic [17:0] b,
    input  logic [47:0] c, input logic [47:0] cs, input logic ci,
    input  logic [47:0] pin, input logic [3:0] cyin,
    output logic [47:0] pout, output logic [3:0] cyout, output logic err);
    logic signed [47:0] sa, sb, prod;
    logic [47:0] x, y, z, w, op2, m;
    logic [48:0] s;
    logic        c0;
    sa   = {{23{a[24]}}, a[24:0]};
    sb   = {{30{b[17]}}, b};
    prod = sa * sb;
    x = (op[1:0] == 2'd0) ? 48'd0 : (op[1:0] == 2'd1) ? prod : (op[1:0] == 2'd2) ? pin : {a, b};
    y = (op[3:2] == 2'd2) ? '1 : (op[3:2] == 2'd3) ? c : 48'd0;
    case (op[6:4])
      3'd1: z = cs;
      3'd2, 3'd4: z = pin;
      3'd3: z = c;
      3'd5: z = $signed(cs) >>> 17;
      3'd6: z = $signed(pin) >>> 17;
      default: z = 48'd0;
    endcase
    err = ((op[1:0] == 2'd1) != (op[3:2] == 2'd1)) || (op[6:4] == 3'd7) || (alu != ADD && alu != SUB);
    w   = x + y + {47'd0, ci};
    c0  = (alu == SUB);
    op2 = c0 ? ~w : w;
    for (int k = 0; k < 4; k++) begin
      m = 48'((49'd1 << (12 * (k + 1))) - 49'd1);
      s = {1'b0, z & m} + {1'b0, op2 & m} + {48'd0, c0};
      cyout[k] = s[12 * (k + 1)];
    end
    if (op[1:0] == 2'd1 && op[3:2] == 2'd1) cyout[3] = 1'b0;
    pout = z + op2 + {47'd0, c0};
    if (err) begin
      pout  = pin;
      cyout = cyin;
    end
  endfunction

  task automatic issue(input logic [6:0] op, input logic [3:0] alu, input logic [29:0] a,
                       input logic [17:0] b, input logic [47:0] c, input logic [47:0] cs,
                       input logic ci, input string tag);
    logic [47:0] pe;
    logic [3:0]  ye;
    logic        ee;
    exp_t        it;
    @(negedge clk);
    opmode_i = op; alumode_i = alu; a_i = a; b_i = b; c_i = c; casc_i = cs; cin_i = ci;
    model(op, alu, a, b, c, cs, ci, mp, mc, pe, ye, ee);
    it.due = 32'(cyc + LAT); it.p = pe; it.cy = ye; it.err = ee;
    exp_q.push_back(it);
    tag_q.push_back(tag);
    mp = pe; mc = ye;
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 1; i++) issue(IDLE, ADD, '0, '0, '0, '0, 1'b0, "R10 idle");
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_p(input logic [47:0] e, input string tag);
    checks++;
    if (p_o !== e || mode_err_o !== 1'b0) begin
      errors++;
      $display("FAIL %s: p_o act %h exp %h err act %b exp 0", tag, p_o, e, mode_err_o);
    end
  endtask

  // monitor: one scoreboard item per due cycle; R9 flags and R13 cascade copy on every item
  always @(negedge clk) begin
    if (exp_q.size() != 0 && exp_q[0].due == 32'(cyc)) begin
      exp_t  it;
      string tg;
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (p_o !== it.p || carry_o !== it.cy || mode_err_o !== it.err || casc_o !== it.p ||
          pat_hit_o !== (it.p == PAT) || pat_inv_hit_o !== (it.p == ~PAT)) begin
        errors++;
        $display("FAIL %s: act p=%h cy=%b err=%b casc=%h pat=%b inv=%b exp p=%h cy=%b err=%b pat=%b inv=%b",
                 tg, p_o, carry_o, mode_err_o, casc_o, pat_hit_o, pat_inv_hit_o,
                 it.p, it.cy, it.err, it.p == PAT, it.p == ~PAT);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: act still running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (p_o !== '0 || carry_o !== '0 || casc_o !== '0 || mode_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R11: act p=%h cy=%b casc=%h err=%b exp all zero", p_o, carry_o, casc_o, mode_err_o);
    end
    rst_n = 1'b1;

    // R1 product, upper A bits ignored, negative operand
    issue(opm(0, 1, 1), ADD, {5'b10101, 25'h1FF_FFFB}, 18'd300, '0, '0, 1'b0, "R1");
    issue(opm(3, 1, 1), ADD, 30'd4000, 18'h3FFF9, 48'd1000, '0, 1'b1, "R1");
    // R8 carry[3] forced low under product
    issue(opm(3, 1, 1), ADD, 30'h1FF_FFFF, 18'd1, 48'd1, '0, 1'b0, "R8");
    // R2 and R10: back-to-back accumulation of the previous result
    issue(opm(0, 0, 2), ADD, '0, '0, '0, '0, 1'b1, "R2");
    issue(opm(0, 0, 2), ADD, '0, '0, '0, '0, 1'b1, "R10");
    issue(opm(0, 0, 2), ADD, '0, '0, '0, '0, 1'b1, "R10");
    issue(opm(0, 0, 3), ADD, 30'h2AAA_AAAA, 18'h15555, '0, '0, 1'b0, "R2");
    // R3
    issue(opm(3, 2, 0), ADD, '0, '0, 48'h0000_0000_1000, '0, 1'b0, "R3");
    issue(opm(0, 3, 0), ADD, '0, '0, 48'h7FFF_0000_0001, '0, 1'b0, "R3");
    // R4
    issue(opm(1, 0, 0), ADD, '0, '0, '0, 48'h1234_5678_9ABC, 1'b0, "R4");
    issue(opm(3, 0, 0), ADD, '0, '0, 48'h0BAD_F00D_0001, '0, 1'b0, "R4");
    issue(opm(4, 0, 0), ADD, '0, '0, '0, '0, 1'b1, "R4");
    // R5
    issue(opm(5, 0, 0), ADD, '0, '0, '0, 48'h8000_0000_0000, 1'b0, "R5");
    issue(opm(6, 0, 0), ADD, '0, '0, '0, '0, 1'b0, "R5");
    // R6
    issue(opm(3, 0, 3), SUB, 30'd0, 18'd40, 48'd100, '0, 1'b1, "R6");
    issue(opm(3, 0, 3), SUB, 30'd0, 18'd10, 48'd5, '0, 1'b0, "R6");
    // R7 illegal selections hold the result
    issue(opm(0, 0, 1), ADD, 30'd7, 18'd7, '0, '0, 1'b0, "R7");
    issue(opm(7, 0, 0), ADD, '0, '0, 48'd9, '0, 1'b0, "R7");
    issue(opm(3, 0, 0), 4'b0001, '0, '0, 48'd9, '0, 1'b0, "R7");
    issue(opm(3, 0, 0), ADD, '0, '0, 48'd9, '0, 1'b0, "R7");
    // R8 every section carries
    issue(opm(3, 3, 0), ADD, '0, '0, 48'h800_800_800_800, '0, 1'b0, "R8");
    // R9
    issue(opm(0, 3, 0), ADD, '0, '0, PAT, '0, 1'b0, "R9");
    issue(opm(0, 3, 0), ADD, '0, '0, ~PAT, '0, 1'b0, "R9");
    drain();

    // R12 result-stage enable
    issue(opm(3, 0, 0), ADD, '0, '0, 48'h0123_4567_89AB, '0, 1'b0, "R12");
    issue(opm(3, 0, 0), ADD, '0, '0, 48'h0123_4567_89AB, '0, 1'b0, "R12");
    while (exp_q.size() != 0) @(negedge clk);
    ce_p = 1'b0;
    c_i  = 48'h0FED_CBA9_8765;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_p(48'h0123_4567_89AB, "R12 ce_p low");
    end
    ce_p = 1'b1;
    @(negedge clk);
    expect_p(48'h0FED_CBA9_8765, "R12 ce_p restored");

    // R12 input-stage enable
    ce_ab = 1'b0;
    c_i   = 48'h0123_4567_89AB;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_p(48'h0FED_CBA9_8765, "R12 ce_ab low");
    end
    ce_ab = 1'b1;
    repeat (LAT) @(negedge clk);
    expect_p(48'h0123_4567_89AB, "R12 ce_ab restored");
    mp = 48'h0123_4567_89AB;
    mc = 4'b0000;
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule